// File: doc/BRIEF.md
# Keyed Configuration Port with GPIO Banks

This block is the configuration front end of a legacy I/O controller. A host reaches it through two byte-wide ports selected by a one-bit address: address 0 holds a register number and address 1 moves data to or from that register. Until the host writes the open key twice in a row to address 0, the register space stays closed. A close key shuts it again. While the space is open, a page-select register decides whether the GPIO page is visible.

The GPIO page holds a set of banks. Each bank has four registers: pin direction, output latch, synchronized pad input and drive style. The drive style is either push-pull or open-drain. Each bank drives per-pin data and enable lines toward the tri-state pads. Identification bytes for the device, its revision and its manufacturer can be read from any page. Banks can be narrower than eight pins. The bits of missing pins read as zero and are never driven.

Reads are combinational and have no side effects. `io_rdata` always shows the value that a read of the port selected by `io_addr` would return. Writes take effect on the rising clock edge where `io_wr` is high.

Top module: `sio_cfg_gpio`

## Requirements
- R1: Two consecutive writes of 0x87 to address 0 open configuration mode. While it is open, every other address-0 write loads the register index, and an address-0 read returns that index.
- R2: Any address-0 write of a value other than 0x87 after a single 0x87 cancels the sequence, and two fresh 0x87 writes are then needed. Address-1 writes do not affect the sequence.
- R3: An address-0 write of 0xAA while open closes configuration mode. While closed, address-1 writes change nothing, and both addresses read 0xFF.
- R4: Register access is indirect: an address-1 access reaches the register whose number was last loaded into the index.
- R5: Register 0x07 is the page select and is readable and writable. Bank registers are visible only while it holds 0x06. Otherwise they read 0x00 and ignore writes, and the pads keep their state.
- R6: The following registers are read-only and readable under any page value: 0x20 device ID high byte (0x05), 0x21 device ID low byte (0x41), 0x22 revision (0x12), 0x23 manufacturer high byte (0x19), 0x24 manufacturer low byte (0x34).
- R7: Bank b occupies registers 0xF0 - 0x10*b through +3: +0 direction, +1 output latch, +2 pad input (read-only), +3 drive style. Unmapped register numbers read 0x00.
- R8: A direction bit of 0 makes the pin an input, and its enable is low. A direction bit of 1 makes it an output.
- R9: For an output pin, a style bit of 1 means push-pull: the enable is high and the pad data equals the latch bit. A style bit of 0 means open-drain: a latch bit of 0 drives low with the enable high, and a latch bit of 1 releases the pin with the enable low.
- R10: The pad-input register shows the pad value sampled through two flops. A pad change made before clock edge k is readable after edge k+1.
- R11: With the default bank widths 8, 8, 8, 4, 4, the bits of missing pins read 0, ignore writes, and are never enabled.
- R12: After reset the port is closed, the index and page select are 0x00, all bank registers are 0x00, and no pad is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe for the port selected by io_addr |
| io_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the port selected by io_addr |
| pad_in | input | 8*NB | Pad levels, 8 lanes per bank |
| pad_out | output | 8*NB | Pad drive data |
| pad_oe | output | 8*NB | Pad drive enable |

## Verification
The bench attacks the unlock sequence with a wrong key between two open keys. A design that only counted open keys would open one write too early. It writes through the data port while closed and then reopens to read the registers back, which catches a decoder that ignores the lock. The pad-input register is read in the cycle just after a pad change and again one cycle later, which exposes a missing or extra synchronizer stage. Every combination of drive style and latch bit is compared against the pad enables on every clock. This catches an open-drain pin that drives high, and a narrow bank that stores or drives its missing bits.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] KEY_OPEN     = 8'h87;
  localparam logic [7:0] KEY_CLOSE    = 8'hAA;
  localparam logic [7:0] REG_PAGE     = 8'h07;
  localparam logic [7:0] PAGE_GPIO    = 8'h06;
  localparam logic [7:0] REG_DEV_HI   = 8'h20;
  localparam logic [7:0] REG_DEV_LO   = 8'h21;
  localparam logic [7:0] REG_REV      = 8'h22;
  localparam logic [7:0] REG_MFG_HI   = 8'h23;
  localparam logic [7:0] REG_MFG_LO   = 8'h24;

  typedef enum logic [1:0] {ST_LOCKED, ST_HALF, ST_OPEN} key_st_t;

  // mask of implemented lanes in a bank of the given width
  function automatic logic [7:0] lane_mask(input int unsigned pins);
    return 8'((16'd1 << pins) - 16'd1);
  endfunction

  // upper register-number nibble of bank b (bases step down from 0xF0)
  function automatic logic [3:0] page_nibble(input int unsigned bank);
    return 4'(15 - bank);
  endfunction

  // a lane is driven when it is an output and either push-pull or pulling low
  function automatic logic [7:0] drive_en(input logic [7:0] dir, input logic [7:0] latch,
                                          input logic [7:0] style);
    return dir & (style | ~latch);
  endfunction
endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       idx_load
);
  key_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      case (st_q)
        ST_LOCKED: st_d = (wdata == KEY_OPEN) ? ST_HALF : ST_LOCKED;
        ST_HALF:   st_d = (wdata == KEY_OPEN) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   if (wdata == KEY_CLOSE) st_d = ST_LOCKED;
        default:   st_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LOCKED;
    else        st_q <= st_d;
  end

  assign cfg_open = (st_q == ST_OPEN);
  assign idx_load = idx_wr && cfg_open && (wdata != KEY_CLOSE);

  assert_open_by_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(idx_wr && wdata == KEY_OPEN));
  assert_bad_key_stays_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && idx_wr && wdata != KEY_OPEN) |=> !cfg_open);
  assert_close_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_wr && wdata == KEY_CLOSE) |=> !cfg_open);
endmodule

// File: rtl/cfgp_gpio_bank.sv
module cfgp_gpio_bank
  import cfgp_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       page_sel,
  input  logic       wr_en,
  input  logic [1:0] offs,
  input  logic [7:0] wdata,
  input  logic [7:0] pad_in,
  output logic [7:0] rdata,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe
);
  localparam logic [7:0] MASK = lane_mask(PINS);

  logic [7:0] dir_q, latch_q, style_q, sync1_q, sync2_q;
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
      style_q <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      age_q   <= '0;
    end else begin
      sync1_q <= pad_in & MASK;
      sync2_q <= sync1_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
      if (page_sel && wr_en) begin
        case (offs)
          2'd0:    dir_q   <= wdata & MASK;
          2'd1:    latch_q <= wdata & MASK;
          2'd3:    style_q <= wdata & MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (page_sel) begin
      case (offs)
        2'd0:    rdata = dir_q;
        2'd1:    rdata = latch_q;
        2'd2:    rdata = sync2_q;
        default: rdata = style_q;
      endcase
    end
  end

  assign pad_oe  = drive_en(dir_q, latch_q, style_q);
  assign pad_out = pad_oe & latch_q;

  assert_input_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (page_sel && wr_en && offs == 2'd0) |=> ((pad_oe & ~$past(wdata)) == 8'h00));
  assert_sync_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync2_q == ($past(pad_in, 2) & MASK)));
  assert_missing_lanes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q | latch_q | style_q | sync2_q | pad_oe) & ~MASK) == 8'h00);
endmodule

// File: rtl/sio_cfg_gpio.sv
module sio_cfg_gpio
  import cfgp_pkg::*;
#(
  parameter int unsigned NB        = 5,
  parameter logic [31:0] BANK_PINS = 32'h0004_4888,
  parameter logic [15:0] DEV_ID    = 16'h0541,
  parameter logic [7:0]  DEV_REV   = 8'h12,
  parameter logic [15:0] MFG_ID    = 16'h1934
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_wr,
  input  logic            io_addr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic [8*NB-1:0] pad_in,
  output logic [8*NB-1:0] pad_out,
  output logic [8*NB-1:0] pad_oe
);
  logic       cfg_open, idx_load, dat_wr, gpio_page;
  logic [7:0] idx_q, page_q, gpio_rd;
  logic [NB-1:0] bank_hit;
  logic [7:0] bank_rd [NB];

  cfgp_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (io_wr && !io_addr),
    .wdata    (io_wdata),
    .cfg_open (cfg_open),
    .idx_load (idx_load)
  );

  assign dat_wr    = io_wr && io_addr && cfg_open;
  assign gpio_page = cfg_open && (page_q == PAGE_GPIO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      page_q <= '0;
    end else begin
      if (idx_load) idx_q <= io_wdata;
      if (dat_wr && idx_q == REG_PAGE) page_q <= io_wdata;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int unsigned PB = int'(BANK_PINS[4*b +: 4]);
    assign bank_hit[b] = gpio_page && (idx_q[7:4] == page_nibble(b)) && (idx_q[3:2] == 2'b00);
    cfgp_gpio_bank #(.PINS(PB)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .page_sel (bank_hit[b]),
      .wr_en    (dat_wr),
      .offs     (idx_q[1:0]),
      .wdata    (io_wdata),
      .pad_in   (pad_in[8*b +: 8]),
      .rdata    (bank_rd[b]),
      .pad_out  (pad_out[8*b +: 8]),
      .pad_oe   (pad_oe[8*b +: 8])
    );
  end

  always_comb begin
    gpio_rd = '0;
    for (int b = 0; b < NB; b++) gpio_rd = gpio_rd | bank_rd[b];
    if (!io_addr)       io_rdata = cfg_open ? idx_q : 8'hFF;
    else if (!cfg_open) io_rdata = 8'hFF;
    else begin
      case (idx_q)
        REG_PAGE:   io_rdata = page_q;
        REG_DEV_HI: io_rdata = DEV_ID[15:8];
        REG_DEV_LO: io_rdata = DEV_ID[7:0];
        REG_REV:    io_rdata = DEV_REV;
        REG_MFG_HI: io_rdata = MFG_ID[15:8];
        REG_MFG_LO: io_rdata = MFG_ID[7:0];
        default:    io_rdata = gpio_rd;
      endcase
    end
  end

  assert_page_frozen_when_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(page_q));
  assert_single_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));
  assert_index_frozen_when_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(idx_q));
endmodule

// File: tb/sim_sio_cfg_gpio.sv
`timescale 1ns/1ps
module sim_sio_cfg_gpio;
  localparam int NB = 5;
  localparam int PW [NB] = '{8, 8, 8, 4, 4};

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_wr = 1'b0, io_addr = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [8*NB-1:0] pad_in = '0, pad_out, pad_oe;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  // reference model
  int m_st = 0;
  logic [7:0] m_idx = 0, m_page = 0;
  logic [7:0] m_dir [NB], m_lat [NB], m_sty [NB];
  logic [8*NB-1:0] m_s1 = '0, m_s2 = '0;

  always #2 clk = ~clk;

  sio_cfg_gpio u0 (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  function automatic logic [7:0] mmask(int b);
    return 8'((1 << PW[b]) - 1);
  endfunction

  function automatic int which_bank(logic [7:0] r);
    for (int b = 0; b < NB; b++)
      if (r >= 8'(240 - 16*b) && r <= 8'(243 - 16*b)) return b;
    return -1;
  endfunction

  function automatic logic [7:0] exp_read(logic a);
    int b;
    if (!a) return (m_st == 2) ? m_idx : 8'hFF;
    if (m_st != 2) return 8'hFF;
    case (m_idx)
      8'h07: return m_page;
      8'h20: return 8'h05;
      8'h21: return 8'h41;
      8'h22: return 8'h12;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      default: ;
    endcase
    b = which_bank(m_idx);
    if (m_page != 8'h06 || b < 0) return 8'h00;
    case (m_idx - 8'(240 - 16*b))
      8'd0: return m_dir[b];
      8'd1: return m_lat[b];
      8'd2: return m_s2[8*b +: 8] & mmask(b);
      default: return m_sty[b];
    endcase
  endfunction

  function automatic void model_write(logic a, logic [7:0] d);
    int b;
    if (!a) begin
      if (m_st == 0)      m_st = (d == 8'h87) ? 1 : 0;
      else if (m_st == 1) m_st = (d == 8'h87) ? 2 : 0;
      else if (d == 8'hAA) m_st = 0;
      else m_idx = d;
    end else if (m_st == 2) begin
      b = which_bank(m_idx);
      if (m_idx == 8'h07) m_page = d;
      else if (m_page == 8'h06 && b >= 0) begin
        case (m_idx - 8'(240 - 16*b))
          8'd0: m_dir[b] = d & mmask(b);
          8'd1: m_lat[b] = d & mmask(b);
          8'd3: m_sty[b] = d & mmask(b);
          default: ;
        endcase
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m_s1 = '0; m_s2 = '0; end
    else begin m_s2 = m_s1; m_s1 = pad_in; end
  end

  // pad comparison on every clock (R8 R9 R11 R12)
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic [8*NB-1:0] eoe, eout;
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < 8; i++) begin
          logic o;
          o = (i < PW[b]) && m_dir[b][i] && (m_sty[b][i] || !m_lat[b][i]);
          eoe[8*b+i]  = o;
          eout[8*b+i] = o && m_lat[b][i];
        end
      vectors++;
      if (pad_oe !== eoe || pad_out !== eout) begin
        miscompares++;
        $display("FAIL R8 R9 R11 pads: oe=%h out=%h expected oe=%h out=%h", pad_oe, pad_out, eoe, eout);
      end
    end
  end

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(logic a, string tag);
    logic [7:0] e;
    @(negedge clk);
    io_addr = a;
    #1;
    e = exp_read(a);
    vectors++;
    if (io_rdata !== e) begin
      miscompares++;
      $display("FAIL %s: read port %0d idx %h got %h expected %h", tag, a, m_idx, io_rdata, e);
    end
  endtask

  task automatic rd_reg(logic [7:0] r, string tag);
    wr(1'b0, r);
    rd(1'b1, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_dir[b] = 0; m_lat[b] = 0; m_sty[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, "R12");
    rd(1'b1, "R12");
    // closed-mode data write must be lost (R3)
    wr(1'b1, 8'h06);
    // broken key sequence (R2)
    wr(1'b0, 8'h87); wr(1'b1, 8'h00); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    rd(1'b0, "R2");
    wr(1'b0, 8'h87);
    rd(1'b0, "R1");
    rd_reg(8'h07, "R3");
    for (int r = 8'h20; r <= 8'h24; r++) rd_reg(8'(r), "R6");
    // bank page hidden until select (R5)
    wr(1'b0, 8'hF0); wr(1'b1, 8'hFF);
    rd(1'b1, "R5");
    wr(1'b0, 8'h07); wr(1'b1, 8'h06);
    rd(1'b1, "R5");
    wr(1'b0, 8'h22); wr(1'b1, 8'h00);
    rd(1'b1, "R6");
    rd_reg(8'h24, "R6");
    // bank registers (R4 R7 R11)
    for (int b = 0; b < NB; b++) begin
      logic [7:0] base;
      base = 8'(240 - 16*b);
      wr(1'b0, base);     wr(1'b1, 8'hFF);
      wr(1'b0, base + 1); wr(1'b1, 8'hA5 ^ 8'(b));
      wr(1'b0, base + 3); wr(1'b1, 8'h3C);
      wr(1'b0, base + 2); wr(1'b1, 8'hFF);
      for (int k = 0; k < 4; k++) rd_reg(base + 8'(k), "R7");
      rd_reg(base, "R11");
    end
    rd_reg(8'hF4, "R7");
    rd_reg(8'hA0, "R7");
    // drive-style combinations on bank 0 (R9)
    wr(1'b0, 8'hF3); wr(1'b1, 8'h00);
    wr(1'b0, 8'hF1); wr(1'b1, 8'h0F);
    @(negedge clk); #1;
    vectors++;
    if (pad_oe[7:0] !== 8'hF0 || pad_out[7:0] !== 8'h00) begin
      miscompares++;
      $display("FAIL R9: oe=%h out=%h expected oe=f0 out=00", pad_oe[7:0], pad_out[7:0]);
    end
    wr(1'b0, 8'hF3); wr(1'b1, 8'hFF);
    wr(1'b0, 8'hF1); wr(1'b1, 8'h5A);
    wr(1'b0, 8'hF0); wr(1'b1, 8'h33);
    // synchronizer latency (R10)
    wr(1'b0, 8'hF2);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      pad_in = {8'h0F ^ 8'(p), 8'hC3, 8'h96, 8'h5A ^ 8'(p), 8'hA5 + 8'(p)};
      rd(1'b1, "R10");
      rd(1'b1, "R10");
      rd(1'b1, "R10");
    end
    rd_reg(8'hC2, "R10");
    rd_reg(8'hB2, "R11");
    // page away from GPIO: reads zero, pads untouched (R5)
    wr(1'b0, 8'h07); wr(1'b1, 8'h01);
    wr(1'b0, 8'hF0); wr(1'b1, 8'h00);
    rd(1'b1, "R5");
    rd_reg(8'h20, "R6");
    wr(1'b0, 8'h07); wr(1'b1, 8'h06);
    // close and try to disturb (R3)
    wr(1'b0, 8'hF0); wr(1'b0, 8'hAA);
    rd(1'b0, "R3");
    rd(1'b1, "R3");
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd(1'b0, "R1");
    rd(1'b1, "R3");
    rd(1'b1, "R4");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule